// File: doc/BRIEF.md
# DMA Completion Interrupt Coalescer

This block sits beside one channel of a DMA engine and decides when that channel raises its interrupt. The engine sends a one-cycle pulse each time a packet finishes. The block counts these pulses and raises a "count reached" event once the configured number of packets has finished. It also runs an inactivity timer, which restarts on every completion. If the timer runs out before the count is reached, it raises a "quiet line" event and restarts the packet count. Software sets the packet threshold, the inactivity timeout and the interrupt enables through a configuration write port, and it reads them back as a packed control word.

Each event sets a sticky pending bit. The interrupt line is a level output: it is high while any pending bit is set and its enable is also set. Software clears pending bits by writing ones to them. The packed status word shows the pending bits, the live packet counter and the live timer value. The timer counts down only on cycles when an external prescaler strobe is high, so a slow time base can drive it.

Top module: `dma_irq_coalescer`

## Requirements
- R1: After reset the control word reads 0x0001_0000 (threshold 1, timeout 0, enables off). The status word reads 0x0001_0000 (counter 1, timer 0, nothing pending), and `irq` is low. With these defaults every completion sets the count-reached pending bit.
- R2: A configuration write stores the threshold in control bits 23:16, the timeout in bits 31:24 and the enables in bits 14:12. All other control bits read 0. On the next cycle the status counter (bits 23:16) shows the newly written threshold.
- R3: A completion decrements the counter. If the counter is 1 or 0 when the completion arrives, the count-reached pending bit (status bit 12) sets and the counter reloads from the threshold.
- R4: A completion loads the timer with the timeout when the timeout is nonzero. It leaves the timer unchanged when the timeout is zero.
- R5: A prescaler strobe decrements a nonzero timer while the timeout is nonzero. When a strobe finds the timer at 1, the timer reaches 0, the quiet-line pending bit (status bit 13) sets, and the counter reloads from the threshold. A completion in the same cycle as a strobe restarts the timer and the strobe is ignored.
- R6: `irq` is high exactly when some pending bit in status 13:12 is set and the matching enable in control 13:12 is also set.
- R7: A status write clears each pending bit whose bit in `stat_clr` (bit 0 for status bit 12, bit 1 for status bit 13) is 1. It leaves the bits whose clear bit is 0 unchanged.
- R8: If an event and a software clear hit the same pending bit in the same cycle, the bit ends set.
- R9: The status word packs the timer in bits 31:24, the counter in 23:16 and the pending bits in 13:12. All other status bits read 0.
- R10: A configuration write in the same cycle as a completion leaves the counter at the new threshold, and that completion does not count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_thr | input | 8 | Packet threshold to write |
| cfg_dly | input | 8 | Inactivity timeout to write |
| cfg_en | input | 3 | Interrupt enables to write (bit 0 count, bit 1 timer, bit 2 spare) |
| stat_we | input | 1 | Status write strobe (write-one-to-clear) |
| stat_clr | input | 2 | Clear mask for pending bits 12 and 13 |
| pkt_done | input | 1 | One-cycle packet-completed pulse |
| tick | input | 1 | Prescaler enable for the timer |
| irq | output | 1 | Level interrupt |
| ctrl_rdata | output | 32 | Packed control readback |
| stat_rdata | output | 32 | Packed status readback |

## Verification
Every state element is one register deep, so the counter, the timer and the pending bits show the effect of a strobe on the clock edge that samples it. `irq` follows the pending and enable registers without any added delay. The bench changes inputs shortly after a rising edge and holds them through the next edge. It then reads the outputs shortly after that edge, exactly one cycle after the stimulus. The checker's properties use the same one-cycle `|=>` relation.

// File: rtl/dic_pkg.sv
package dic_pkg;
  // Layout of the packed words; software decodes these positions.
  localparam int CNT_W    = 8;
  localparam int TMR_W    = 8;
  localparam int EN_W     = 3;
  localparam int PEND_N   = 2;
  localparam int THR_LSB  = 16;
  localparam int DLY_LSB  = 24;
  localparam int FLAG_LSB = 12;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [TMR_W-1:0] tmr_t;

  // Counter value at which the next completion fires the count event.
  function automatic logic cnt_last(input cnt_t c);
    return (c <= cnt_t'(1));
  endfunction

  // Next counter value for a completion that does not fire.
  function automatic cnt_t cnt_dec(input cnt_t c);
    return c - cnt_t'(1);
  endfunction

  // Timer value at which a tick makes it expire.
  function automatic logic tmr_last(input tmr_t t);
    return (t == tmr_t'(1));
  endfunction

  function automatic logic [31:0] pack_ctrl(input tmr_t d, input cnt_t t,
                                            input logic [EN_W-1:0] e);
    logic [31:0] w;
    w = '0;
    w[DLY_LSB +: TMR_W]   = d;
    w[THR_LSB +: CNT_W]   = t;
    w[FLAG_LSB +: EN_W]   = e;
    return w;
  endfunction

  function automatic logic [31:0] pack_stat(input tmr_t t, input cnt_t c,
                                            input logic [PEND_N-1:0] p);
    logic [31:0] w;
    w = '0;
    w[DLY_LSB +: TMR_W]   = t;
    w[THR_LSB +: CNT_W]   = c;
    w[FLAG_LSB +: PEND_N] = p;
    return w;
  endfunction
endpackage

// File: rtl/dic_count.sv
module dic_count
  import dic_pkg::*;
#(
  parameter cnt_t RST_VAL = cnt_t'(1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_load,
  input  cnt_t cfg_val,
  input  cnt_t thr,
  input  logic pkt,
  input  logic tmr_exp,
  output cnt_t cnt,
  output logic hit
);
  cnt_t cnt_q;

  // A configuration write takes the cycle; that completion is not counted.
  always_comb hit = pkt && !cfg_load && cnt_last(cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= RST_VAL;
    else if (cfg_load)   cnt_q <= cfg_val;
    else if (pkt)        cnt_q <= hit ? thr : cnt_dec(cnt_q);
    else if (tmr_exp)    cnt_q <= thr;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/dic_timer.sv
module dic_timer
  import dic_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  tmr_t dly,
  input  logic pkt,
  input  logic tick,
  output tmr_t tmr,
  output logic expire
);
  tmr_t tmr_q;
  logic armed;
  logic restart;
  logic step;

  always_comb begin
    armed   = (dly != '0);
    restart = pkt && armed;
    step    = tick && armed && !pkt && (tmr_q != '0);
    expire  = step && tmr_last(tmr_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       tmr_q <= '0;
    else if (restart) tmr_q <= dly;
    else if (step)    tmr_q <= tmr_q - tmr_t'(1);
  end

  assign tmr = tmr_q;
endmodule

// File: rtl/dic_pending.sv
module dic_pending
  import dic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PEND_N-1:0] set,
  input  logic [PEND_N-1:0] clr,
  input  logic [PEND_N-1:0] en,
  output logic [PEND_N-1:0] pend,
  output logic              irq
);
  logic [PEND_N-1:0] pend_q;

  for (genvar i = 0; i < PEND_N; i++) begin : g_bit
    // A new event outranks a same-cycle clear.
    always_ff @(posedge clk) begin
      if (!rst_n)      pend_q[i] <= 1'b0;
      else if (set[i]) pend_q[i] <= 1'b1;
      else if (clr[i]) pend_q[i] <= 1'b0;
    end
  end

  assign pend = pend_q;
  assign irq  = |(pend_q & en);
endmodule

// File: rtl/dma_irq_coalescer.sv
module dma_irq_coalescer
  import dic_pkg::*;
#(
  parameter cnt_t RST_THR = cnt_t'(1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CNT_W-1:0]  cfg_thr,
  input  logic [TMR_W-1:0]  cfg_dly,
  input  logic [EN_W-1:0]   cfg_en,
  input  logic              stat_we,
  input  logic [PEND_N-1:0] stat_clr,
  input  logic              pkt_done,
  input  logic              tick,
  output logic              irq,
  output logic [31:0]       ctrl_rdata,
  output logic [31:0]       stat_rdata
);
  cnt_t              thr_q;
  tmr_t              dly_q;
  logic [EN_W-1:0]   en_q;

  cnt_t              cnt;
  tmr_t              tmr;
  logic              ioc_evt;
  logic              dly_evt;
  logic [PEND_N-1:0] pend;
  logic [PEND_N-1:0] clr_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q <= RST_THR;
      dly_q <= '0;
      en_q  <= '0;
    end else if (cfg_we) begin
      thr_q <= cfg_thr;
      dly_q <= cfg_dly;
      en_q  <= cfg_en;
    end
  end

  dic_count #(.RST_VAL(RST_THR)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_load(cfg_we),
    .cfg_val (cfg_thr),
    .thr     (thr_q),
    .pkt     (pkt_done),
    .tmr_exp (dly_evt),
    .cnt     (cnt),
    .hit     (ioc_evt)
  );

  dic_timer u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .dly   (dly_q),
    .pkt   (pkt_done),
    .tick  (tick),
    .tmr   (tmr),
    .expire(dly_evt)
  );

  assign clr_req = stat_we ? stat_clr : '0;

  dic_pending u_pend (
    .clk  (clk),
    .rst_n(rst_n),
    .set  ({dly_evt, ioc_evt}),
    .clr  (clr_req),
    .en   (en_q[PEND_N-1:0]),
    .pend (pend),
    .irq  (irq)
  );

  assign ctrl_rdata = pack_ctrl(dly_q, thr_q, en_q);
  assign stat_rdata = pack_stat(tmr, cnt, pend);
endmodule

// File: rtl/dic_checker.sv
module dic_checker
  import dic_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [CNT_W-1:0]  cfg_thr,
  input logic              stat_we,
  input logic [PEND_N-1:0] stat_clr,
  input logic              pkt_done,
  input logic              irq,
  input logic [31:0]       ctrl_rdata,
  input logic [31:0]       stat_rdata,
  input logic              ioc_evt,
  input logic              dly_evt
);
  assert_cfg_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> stat_rdata[23:16] == $past(cfg_thr));

  assert_cnt_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && !cfg_we && stat_rdata[23:16] > 8'd1)
      |=> stat_rdata[23:16] == $past(stat_rdata[23:16]) - 8'd1);

  assert_ioc_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && !cfg_we && stat_rdata[23:16] <= 8'd1) |=> stat_rdata[12]);

  assert_tmr_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && ctrl_rdata[31:24] != 8'd0)
      |=> stat_rdata[31:24] == $past(ctrl_rdata[31:24]));

  assert_tmr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && ctrl_rdata[31:24] == 8'd0) |=> $stable(stat_rdata[31:24]));

  assert_expire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dly_evt |=> (stat_rdata[13] && stat_rdata[31:24] == 8'd0));

  assert_irq_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(stat_rdata[13:12] & ctrl_rdata[13:12]));

  assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && stat_clr[1] && !dly_evt) |=> !stat_rdata[13]);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ioc_evt |=> stat_rdata[12]);
endmodule

bind dma_irq_coalescer dic_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_thr   (cfg_thr),
  .stat_we   (stat_we),
  .stat_clr  (stat_clr),
  .pkt_done  (pkt_done),
  .irq       (irq),
  .ctrl_rdata(ctrl_rdata),
  .stat_rdata(stat_rdata),
  .ioc_evt   (ioc_evt),
  .dly_evt   (dly_evt)
);

// File: tb/dma_irq_coalescer_tb.sv
module dma_irq_coalescer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_thr = '0;
  logic [7:0]  cfg_dly = '0;
  logic [2:0]  cfg_en = '0;
  logic        stat_we = 1'b0;
  logic [1:0]  stat_clr = '0;
  logic        pkt_done = 1'b0;
  logic        tick = 1'b0;
  logic        irq;
  logic [31:0] ctrl_rdata;
  logic [31:0] stat_rdata;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  dma_irq_coalescer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_thr(cfg_thr),
    .cfg_dly(cfg_dly), .cfg_en(cfg_en), .stat_we(stat_we),
    .stat_clr(stat_clr), .pkt_done(pkt_done), .tick(tick), .irq(irq),
    .ctrl_rdata(ctrl_rdata), .stat_rdata(stat_rdata)
  );

  // {pkt, tick, clr[1:0], cnt[7:0], tmr[7:0], pend[1:0], irq}
  // after cfg threshold 3, timeout 4, enables 3'b011
  localparam logic [22:0] VEC [15] = '{
    {1'b1, 1'b0, 2'b00, 8'd2, 8'd4, 2'b00, 1'b0},
    {1'b0, 1'b1, 2'b00, 8'd2, 8'd3, 2'b00, 1'b0},
    {1'b0, 1'b1, 2'b00, 8'd2, 8'd2, 2'b00, 1'b0},
    {1'b1, 1'b0, 2'b00, 8'd1, 8'd4, 2'b00, 1'b0},
    {1'b1, 1'b0, 2'b00, 8'd3, 8'd4, 2'b01, 1'b1},
    {1'b1, 1'b0, 2'b01, 8'd2, 8'd4, 2'b00, 1'b0},
    {1'b0, 1'b1, 2'b00, 8'd2, 8'd3, 2'b00, 1'b0},
    {1'b0, 1'b1, 2'b00, 8'd2, 8'd2, 2'b00, 1'b0},
    {1'b0, 1'b1, 2'b00, 8'd2, 8'd1, 2'b00, 1'b0},
    {1'b0, 1'b1, 2'b00, 8'd3, 8'd0, 2'b10, 1'b1},
    {1'b0, 1'b1, 2'b00, 8'd3, 8'd0, 2'b10, 1'b1},
    {1'b1, 1'b1, 2'b00, 8'd2, 8'd4, 2'b10, 1'b1},
    {1'b1, 1'b0, 2'b10, 8'd1, 8'd4, 2'b00, 1'b0},
    {1'b1, 1'b0, 2'b01, 8'd3, 8'd4, 2'b01, 1'b1},
    {1'b0, 1'b0, 2'b11, 8'd3, 8'd4, 2'b00, 1'b0}
  };

  function automatic logic [31:0] exp_stat(input logic [7:0] t,
                                           input logic [7:0] c,
                                           input logic [1:0] p);
    return {t, c, 2'b00, p, 12'h000};
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Apply one cycle of stimulus; outputs are read 1 ns after the edge.
  task automatic step(input logic pk, input logic tk, input logic sw,
                      input logic [1:0] cl, input logic cw,
                      input logic [7:0] th, input logic [7:0] dl,
                      input logic [2:0] en);
    pkt_done = pk; tick = tk; stat_we = sw; stat_clr = cl;
    cfg_we = cw; cfg_thr = th; cfg_dly = dl; cfg_en = en;
    @(posedge clk);
    #1;
    pkt_done = 1'b0; tick = 1'b0; stat_we = 1'b0; stat_clr = '0;
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    check("R1 ctrl", ctrl_rdata, 32'h0001_0000);
    check("R1 stat", stat_rdata, 32'h0001_0000);
    check("R1 irq", {31'd0, irq}, 32'd0);
    // R1 default threshold fires on every packet (enables off -> no irq)
    step(1, 0, 0, 2'b00, 0, 0, 0, 0);
    check("R1 default fire", stat_rdata, exp_stat(8'd0, 8'd1, 2'b01));
    check("R6 disabled irq", {31'd0, irq}, 32'd0);
    step(0, 0, 1, 2'b01, 0, 0, 0, 0);
    check("R7 clear", stat_rdata, exp_stat(8'd0, 8'd1, 2'b00));

    // R2 configure for the vector walk
    step(0, 0, 0, 2'b00, 1, 8'd3, 8'd4, 3'b011);
    check("R2 ctrl", ctrl_rdata, 32'h0403_3000);
    check("R2 reload", stat_rdata, exp_stat(8'd0, 8'd3, 2'b00));

    // Vector walk: R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < 15; i++) begin
      logic [22:0] v;
      v = VEC[i];
      step(v[22], v[21], v[20:19] != 2'b00, v[20:19], 0, 0, 0, 0);
      check($sformatf("R9 R3 R5 R8 vec%0d stat", i), stat_rdata,
            exp_stat(v[10:3], v[18:11], v[2:1]));
      check($sformatf("R6 vec%0d irq", i), {31'd0, irq}, {31'd0, v[0]});
    end

    // R2 field storage with all ones
    step(0, 0, 0, 2'b00, 1, 8'hFF, 8'hFF, 3'b111);
    check("R2 all ones", ctrl_rdata, 32'hFFFF_7000);
    check("R2 cnt ff", stat_rdata, exp_stat(8'd4, 8'hFF, 2'b00));

    // R6 mask: only the timer enable set, count event pending
    step(0, 0, 0, 2'b00, 1, 8'd1, 8'd0, 3'b010);
    step(1, 0, 0, 2'b00, 0, 0, 0, 0);
    check("R6 masked", {31'd0, irq}, 32'd0);
    check("R4 zero timeout holds", stat_rdata, exp_stat(8'd4, 8'd1, 2'b01));
    step(0, 1, 0, 2'b00, 0, 0, 0, 0);
    check("R5 tick ignored with zero timeout", stat_rdata,
          exp_stat(8'd4, 8'd1, 2'b01));
    step(0, 0, 0, 2'b00, 1, 8'd1, 8'd0, 3'b001);
    check("R6 unmasked", {31'd0, irq}, 32'd1);

    // R10 config write with a completion in the same cycle
    step(0, 0, 1, 2'b11, 0, 0, 0, 0);
    step(1, 0, 0, 2'b00, 1, 8'd5, 8'd0, 3'b001);
    check("R10 cfg beats packet", stat_rdata, exp_stat(8'd4, 8'd5, 2'b00));

    // R3 threshold zero fires at once
    step(0, 0, 0, 2'b00, 1, 8'd0, 8'd0, 3'b001);
    step(1, 0, 0, 2'b00, 0, 0, 0, 0);
    check("R3 threshold zero", stat_rdata, exp_stat(8'd4, 8'd0, 2'b01));
    check("R6 irq thr0", {31'd0, irq}, 32'd1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule